// File: doc/BRIEF.md
# Synchronous SRAM Read Return Path

This block sits between the input register stage of a synchronous burst SRAM and its shared bidirectional data pins. Each cycle it receives one registered command (read, write, deselect or none) and, one cycle after each read, the raw word from the storage array. It produces the value for the data bus and the enable of its tri-state driver.

Two static configuration inputs shape the timing. `cfg_flow` chooses between a pipelined return, where the array word passes through a rising-edge output register, and a flow-through return, where it goes straight to the pins. `cfg_dcd` chooses how late a deselect takes the bus drive away: either one stage before read data would arrive, or at the same depth as read data. Tying both low gives the power-up default: pipelined output with single-cycle deselect. The active-low output enable `oe_n` and the `sleep` input gate the driver combinationally. While `sleep` is high, incoming commands are discarded. Burst address generation happens upstream. A burst reaches this block as one read command per beat, so the first beat pays the full latency and each later beat arrives one cycle after the previous one.

Top module: `sync_rd_return`

## Requirements
- R1: With `cfg_flow`=0, a read command present in cycle c makes `dq_oe` high in cycle c+2, with `dq_out` equal to the `arr_rdata` value of cycle c+1.
- R2: With `cfg_flow`=1, a read command present in cycle c makes `dq_oe` high in cycle c+1, with `dq_out` equal to the `arr_rdata` value of that same cycle.
- R3: Read commands in consecutive cycles give consecutive driven cycles, one per read, so a four-beat burst drives the bus for exactly four cycles.
- R4: With `cfg_dcd`=0, a deselect in cycle c forces `dq_oe` low in cycle c+1 when pipelined and in cycle c itself when flow-through. This cuts off the data of a read issued in cycle c-1.
- R5: With `cfg_dcd`=1, a deselect in cycle c does not cut off the data of a read issued in cycle c-1. The drive turns off at the point where the deselect's own read data would have appeared.
- R6: `dq_oe` is low whenever `oe_n` is high. This acts within the cycle, without waiting for a clock edge.
- R7: `dq_oe` is low in any cycle in which `sleep` is high.
- R8: Commands presented while `sleep` is high are ignored: a read during sleep never produces a driven cycle.
- R9: In a cycle that carries a write command, `dq_oe` is low, even if read data from an earlier read is due in that cycle.
- R10: While `rst_n` is low, `dq_oe` is low.
- R11: With both `cfg_flow` and `cfg_dcd` low, the block behaves as pipelined (R1) with single-cycle deselect (R4).
- R12: When several command inputs are high in the same cycle, deselect wins over write and write wins over read. A read asserted together with write or deselect therefore drives nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with `clk` |
| cmd_rd | input | 1 | Registered read command for this cycle |
| cmd_wr | input | 1 | Registered write command for this cycle; write data is sampled in this cycle |
| cmd_desel | input | 1 | Registered deselect command for this cycle |
| arr_rdata | input | W | Array read word, valid in the cycle after a read command |
| cfg_flow | input | 1 | Static: 1 = flow-through return, 0 = pipelined return |
| cfg_dcd | input | 1 | Static: 1 = dual-cycle deselect, 0 = single-cycle deselect |
| oe_n | input | 1 | Active-low output enable, combinational effect |
| sleep | input | 1 | Low-power request; gates the driver and discards commands |
| dq_out | output | W | Value for the data bus |
| dq_oe | output | 1 | Tri-state enable for the data bus |

## Verification
The properties assume that `cfg_flow` and `cfg_dcd` change only while `rst_n` is low, and that `oe_n` holds steady around each rising edge. This lets the sampled enable be compared with commands and array words from earlier cycles. The bench sets the modes only inside a reset window. It drives the command inputs, `sleep` and `oe_n` shortly after each edge. The only exception is one directed pulse on `oe_n` in the middle of a cycle, which is withdrawn well before the next edge. The random stimulus sometimes raises several command inputs together, which exercises the priority order the properties are written against.

// File: rtl/srr_pkg.sv
`timescale 1ns/1ps
package srr_pkg;
  typedef logic [1:0] kind_t;
  localparam kind_t KIND_NOP = 2'd0;
  localparam kind_t KIND_RD  = 2'd1;
  localparam kind_t KIND_WR  = 2'd2;
  localparam kind_t KIND_DS  = 2'd3;
  // deepest read latency (pipelined return), in stages after capture
  localparam int unsigned MAX_LAT = 2;
endpackage

// File: rtl/srr_kind_pipe.sv
`timescale 1ns/1ps
module srr_kind_pipe
  import srr_pkg::*;
#(
  parameter int unsigned DEPTH = MAX_LAT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  kind_t                cur_i,
  output logic [DEPTH:0][1:0]  taps_o
);
  logic [DEPTH:1][1:0] stg_q;
  logic [DEPTH:1][1:0] stg_d;

  for (genvar i = 1; i <= DEPTH; i++) begin : g_stage
    if (i == 1) begin : g_head
      assign stg_d[i] = cur_i;
    end else begin : g_tail
      assign stg_d[i] = stg_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q <= stg_d;
    end
  end

  assign taps_o[0]       = cur_i;
  assign taps_o[DEPTH:1] = stg_q;
endmodule

// File: rtl/srr_data.sv
`timescale 1ns/1ps
module srr_data #(
  parameter int unsigned W = 36
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         flow_i,
  input  logic [W-1:0] arr_i,
  output logic [W-1:0] dout_o
);
  logic [W-1:0] data_q;
  logic [W-1:0] data_d;

  always_comb begin
    data_d = data_q;
    if (load_i) begin
      data_d = arr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else begin
      data_q <= data_d;
    end
  end

  assign dout_o = flow_i ? arr_i : data_q;
endmodule

// File: rtl/srr_drive.sv
`timescale 1ns/1ps
module srr_drive
  import srr_pkg::*;
#(
  parameter int unsigned DEPTH = MAX_LAT
) (
  input  logic [DEPTH:0][1:0] taps_i,
  input  logic                cfg_flow,
  input  logic                cfg_dcd,
  input  logic                oe_n,
  input  logic                sleep,
  output logic                drive_o
);
  localparam int unsigned SELW = $clog2(DEPTH + 1);

  logic [SELW-1:0] rd_sel;
  logic [SELW-1:0] ds_sel;
  logic            rd_valid;
  logic            ds_hit;
  logic            wr_hit;

  always_comb begin
    rd_sel   = cfg_flow ? SELW'(DEPTH - 1) : SELW'(DEPTH);
    ds_sel   = cfg_dcd ? rd_sel : rd_sel - SELW'(1);
    rd_valid = (taps_i[rd_sel] == KIND_RD);
    ds_hit   = (taps_i[ds_sel] == KIND_DS);
    wr_hit   = (taps_i[0] == KIND_WR);
    drive_o  = rd_valid & ~ds_hit & ~wr_hit & ~oe_n & ~sleep;
  end
endmodule

// File: rtl/sync_rd_return.sv
`timescale 1ns/1ps
module sync_rd_return
  import srr_pkg::*;
#(
  parameter int unsigned W = 36
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_rd,
  input  logic         cmd_wr,
  input  logic         cmd_desel,
  input  logic [W-1:0] arr_rdata,
  input  logic         cfg_flow,
  input  logic         cfg_dcd,
  input  logic         oe_n,
  input  logic         sleep,
  output logic [W-1:0] dq_out,
  output logic         dq_oe
);
  localparam int unsigned DEPTH = MAX_LAT;

  kind_t                cur_kind;
  logic [DEPTH:0][1:0]  taps;

  // R12: deselect over write over read; sleep discards all (R8)
  always_comb begin
    if (sleep)          cur_kind = KIND_NOP;
    else if (cmd_desel) cur_kind = KIND_DS;
    else if (cmd_wr)    cur_kind = KIND_WR;
    else if (cmd_rd)    cur_kind = KIND_RD;
    else                cur_kind = KIND_NOP;
  end

  srr_kind_pipe #(.DEPTH(DEPTH)) u_pipe (
    .clk    (clk),
    .rst_n  (rst_n),
    .cur_i  (cur_kind),
    .taps_o (taps)
  );

  srr_data #(.W(W)) u_data (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (taps[1] == KIND_RD),
    .flow_i (cfg_flow),
    .arr_i  (arr_rdata),
    .dout_o (dq_out)
  );

  srr_drive #(.DEPTH(DEPTH)) u_drive (
    .taps_i   (taps),
    .cfg_flow (cfg_flow),
    .cfg_dcd  (cfg_dcd),
    .oe_n     (oe_n),
    .sleep    (sleep),
    .drive_o  (dq_oe)
  );
endmodule

// File: rtl/sync_rd_return_chk.sv
`timescale 1ns/1ps
module sync_rd_return_chk #(
  parameter int unsigned W = 36
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmd_rd,
  input logic         cmd_wr,
  input logic         cmd_desel,
  input logic [W-1:0] arr_rdata,
  input logic         cfg_flow,
  input logic         cfg_dcd,
  input logic         oe_n,
  input logic         sleep,
  input logic [W-1:0] dq_out,
  input logic         dq_oe
);
  logic ds_eff;
  logic wr_eff;
  logic rd_eff;
  assign ds_eff = cmd_desel & ~sleep;
  assign wr_eff = cmd_wr & ~cmd_desel & ~sleep;
  assign rd_eff = cmd_rd & ~cmd_wr & ~cmd_desel & ~sleep;

  // R6
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);
  // R7
  sleep_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dq_oe);
  // R9
  wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_eff |-> !dq_oe);
  // R1
  pipe_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_flow && dq_oe) |-> $past(rd_eff, 2));
  // R1
  pipe_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_flow && dq_oe) |-> (dq_out == $past(arr_rdata)));
  // R2
  flow_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_flow && dq_oe) |-> $past(rd_eff));
  // R2
  flow_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_flow && dq_oe) |-> (dq_out == arr_rdata));
  // R4
  scd_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_flow && !cfg_dcd && dq_oe) |-> !$past(ds_eff));
  // R4
  scd_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_flow && !cfg_dcd && dq_oe) |-> !ds_eff);
endmodule

bind sync_rd_return sync_rd_return_chk #(.W(W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_rd    (cmd_rd),
  .cmd_wr    (cmd_wr),
  .cmd_desel (cmd_desel),
  .arr_rdata (arr_rdata),
  .cfg_flow  (cfg_flow),
  .cfg_dcd   (cfg_dcd),
  .oe_n      (oe_n),
  .sleep     (sleep),
  .dq_out    (dq_out),
  .dq_oe     (dq_oe)
);

// File: tb/sync_rd_return_tb_top.sv
`timescale 1ns/1ps
module sync_rd_return_tb_top;
  import srr_pkg::*;
  localparam int W = 36;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cmd_rd, cmd_wr, cmd_desel;
  logic [W-1:0] arr_rdata;
  logic         cfg_flow, cfg_dcd, oe_n, sleep;
  logic [W-1:0] dq_out;
  logic         dq_oe;

  always #2.5 clk = ~clk;

  sync_rd_return #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
    .cmd_desel(cmd_desel), .arr_rdata(arr_rdata), .cfg_flow(cfg_flow),
    .cfg_dcd(cfg_dcd), .oe_n(oe_n), .sleep(sleep), .dq_out(dq_out),
    .dq_oe(dq_oe)
  );

  int           checks = 0;
  int           errors = 0;
  logic [1:0]   hk [4];
  int           cn;
  logic [W-1:0] arr_prev;
  string        mt;

  // R12 priority, R8 sleep discard
  function automatic logic [1:0] kind_of(input logic rd, wr, ds, sl);
    if (sl) return KIND_NOP;
    if (ds) return KIND_DS;
    if (wr) return KIND_WR;
    if (rd) return KIND_RD;
    return KIND_NOP;
  endfunction

  function automatic logic exp_drive(input logic on, sl);
    int lat;
    int dsel;
    lat  = cfg_flow ? 1 : 2;
    dsel = cfg_dcd ? lat : lat - 1;
    return (hk[(cn - lat) & 3] == KIND_RD) && (hk[(cn - dsel) & 3] != KIND_DS)
        && (hk[cn & 3] != KIND_WR) && !on && !sl;
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic rd, wr, ds, sl, on, input string tag);
    logic         e_oe;
    logic [W-1:0] e_d;
    @(posedge clk);
    #1;
    cmd_rd = rd; cmd_wr = wr; cmd_desel = ds; sleep = sl; oe_n = on;
    arr_prev  = arr_rdata;
    arr_rdata = W'({$urandom(), $urandom()});
    cn++;
    hk[cn & 3] = kind_of(rd, wr, ds, sl);
    #2;
    e_oe = exp_drive(on, sl);
    e_d  = cfg_flow ? arr_rdata : arr_prev;
    chk(dq_oe === e_oe, tag, W'(dq_oe), W'(e_oe));
    if (e_oe) chk(dq_out === e_d, tag, dq_out, e_d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, mt);
  endtask

  task automatic do_reset(input logic fl, input logic dc);
    @(posedge clk);
    #1;
    rst_n = 1'b0;
    cmd_rd = 0; cmd_wr = 0; cmd_desel = 0; sleep = 0; oe_n = 0;
    cfg_flow = fl; cfg_dcd = dc;
    repeat (3) @(posedge clk);
    #3;
    // R10
    chk(dq_oe === 1'b0, "R10", W'(dq_oe), '0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) hk[i] = KIND_NOP;
    cn = 4;
    mt = fl ? "R2" : "R1";
  endtask

  task automatic directed();
    int lat;
    int n;
    lat = cfg_flow ? 1 : 2;
    // R1 / R2: first-beat latency
    cyc(1, 0, 0, 0, 0, mt);
    for (int i = 1; i <= 2; i++) begin
      cyc(0, 0, 0, 0, 0, mt);
      chk(dq_oe === (i == lat), mt, W'(dq_oe), W'(i == lat));
    end
    idle(2);
    // R3: four-beat burst drives four cycles
    n = 0;
    for (int i = 0; i < 8; i++) begin
      cyc(i < 4, 0, 0, 0, 0, "R3");
      if (dq_oe) n++;
    end
    chk(n == 4, "R3", W'(n), W'(4));
    idle(2);
    // R4 / R5: deselect right after two reads
    for (int i = 0; i < 4; i++) begin
      cyc(i < 2, 0, i == 2, 0, 0, cfg_dcd ? "R5" : "R4");
      if (i == lat + 1)
        chk(dq_oe === cfg_dcd, cfg_dcd ? "R5" : "R4", W'(dq_oe), W'(cfg_dcd));
    end
    idle(3);
    // R9: write in the cycle read data is due
    for (int i = 0; i <= lat; i++) cyc(i == 0, i == lat, 0, 0, 0, "R9");
    chk(dq_oe === 1'b0, "R9", W'(dq_oe), '0);
    idle(3);
    // R7: sleep in the cycle read data is due
    for (int i = 0; i <= lat; i++) cyc(i == 0, 0, 0, i == lat, 0, "R7");
    chk(dq_oe === 1'b0, "R7", W'(dq_oe), '0);
    idle(3);
    // R8: read issued during sleep never drives
    n = 0;
    for (int i = 0; i < 4; i++) begin
      cyc(i == 0, 0, 0, i == 0, 0, "R8");
      if (dq_oe) n++;
    end
    chk(n == 0, "R8", W'(n), '0);
    idle(2);
    // R6: oe_n acts within the cycle
    for (int i = 0; i <= lat; i++) cyc(i == 0, 0, 0, 0, 0, "R6");
    chk(dq_oe === 1'b1, "R6", W'(dq_oe), W'(1));
    oe_n = 1'b1;
    #0.5;
    chk(dq_oe === 1'b0, "R6", W'(dq_oe), '0);
    oe_n = 1'b0;
    #0.5;
    chk(dq_oe === 1'b1, "R6", W'(dq_oe), W'(1));
    idle(3);
    // R12: read with write, read with deselect
    n = 0;
    for (int i = 0; i < 8; i++) begin
      cyc(i == 0 || i == 4, i == 0, i == 4, 0, 0, "R12");
      if (dq_oe) n++;
    end
    chk(n == 0, "R12", W'(n), '0);
    idle(2);
  endtask

  task automatic random_run(input int n);
    int r;
    for (int i = 0; i < n; i++) begin
      r = int'($urandom_range(99));
      cyc(r < 55 || r >= 95, (r >= 55 && r < 70) || r >= 97,
          (r >= 70 && r < 82) || r == 99,
          $urandom_range(19) == 0, $urandom_range(9) == 0, mt);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20417));
    rst_n = 1'b0;
    cmd_rd = 0; cmd_wr = 0; cmd_desel = 0; sleep = 0; oe_n = 0;
    cfg_flow = 0; cfg_dcd = 0;
    arr_rdata = '0; arr_prev = '0;
    cn = 4;
    mt = "R1";
    // R11: both mode inputs low -> pipelined return, single-cycle deselect
    do_reset(0, 0);
    for (int i = 0; i < 4; i++) begin
      cyc(i < 2, 0, i == 2, 0, 0, "R11");
      if (i == 2) chk(dq_oe === 1'b1, "R11", W'(dq_oe), W'(1));
      if (i == 3) chk(dq_oe === 1'b0, "R11", W'(dq_oe), '0);
    end
    idle(3);
    for (int m = 0; m < 4; m++) begin
      do_reset(m[0], m[1]);
      directed();
      random_run(600);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule